// File: doc/BRIEF.md
# Thresholded event counter bank

This block is a small performance-monitoring unit built from four programmable counters and one fixed counter, all 48 bits wide. Each programmable counter takes a multi-bit increment from its event source every cycle. Its control word selects one of three ways to count. It can add the raw increment. It can add one on each cycle whose increment passes a threshold compare, and that compare can be inverted. It can add one on each cycle where the event appears after being absent. The fixed counter only accumulates its raw increment.

A carry out of the top bit of any counter sets a sticky flag in a global status word. Software clears a flag by writing one to the matching bit of a separate clear register. An interrupt request stays high while any flag is set whose counter has its overflow interrupt enable on.

Software reaches every register through a plain single-cycle register port. A write takes effect at the clock edge, and read data is a combinational function of the address. The event inputs are sampled every cycle with no handshake and no back-pressure: a source that presents a value has it seen in that same cycle.

Top module: `evt_ctr_bank`

## Requirements
- R1: A counter whose enable bit is 0 keeps its value, whatever its event input does (a software write to the counter still loads it).
- R2: With edge detect clear and threshold 0, an enabled programmable counter adds the full incoming value each cycle, modulo 2^48.
- R3: With edge detect clear and a nonzero threshold, an enabled counter adds exactly 1 on a cycle whose incoming value is greater than or equal to the threshold, and 0 otherwise.
- R4: With the invert bit set and a nonzero threshold, the compare becomes "incoming value less than threshold"; a match still adds exactly 1.
- R5: With edge detect set, an enabled counter adds 1 only on a cycle whose incoming value is nonzero after a zero value in the previous cycle; edge detect takes priority over the threshold compare.
- R6: The fixed counter adds its raw incoming value each cycle while its enable (fixed control bit 0) is 1.
- R7: A carry out of bit 47 sets a status flag: status bit i for programmable counter i (bits 3:0), bit 31 for the fixed counter. All flags and counters reset to 0.
- R8: Status bits 30:4 read as 0, and writes to the status register change nothing.
- R9: Writing 1 to a bit of the clear register clears the matching status bit; writing 0 leaves it; the clear register always reads 0.
- R10: If a counter overflows in the same cycle that software clears its flag, the flag ends up 1.
- R11: `irq` is 1 exactly while some status flag is 1 whose counter's overflow interrupt enable is 1 (programmable control bit 17, fixed control bit 1).
- R12: Register map by address: 0..3 programmable control, 4..7 programmable counters, 8 fixed control, 9 fixed counter, 10 status, 11 clear; other addresses read 0. Programmable control fields: event select 7:0, unit mask 15:8, enable 16, interrupt enable 17, edge detect 18, invert 19, threshold 31:24. A write to a counter loads it and overrides counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_inc | input | NUM_PROG x INC_W | Per-cycle event increments of the programmable counters |
| fix_inc | input | INC_W | Per-cycle event increment of the fixed counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request (level) |

## Verification
The checker assumes at most one register access per cycle and that a counter being loaded is exempt from the hold and step checks in that cycle, since a load may move it arbitrarily. It also assumes reset is applied before any event input carries meaning. The bench drives every input half a cycle away from the sampling edge and issues one register operation at a time. In the cycles that a step or hold property covers, it changes a counter only through its event input.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int THR_W = 8;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [3:0]       spare;
    logic             inv;
    logic             edge_det;
    logic             ovf_ie;
    logic             en;
    logic [7:0]       umask;
    logic [7:0]       evsel;
  } prog_ctl_t;

  typedef struct packed {
    logic ovf_ie;
    logic en;
  } fix_ctl_t;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_ctr_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             edge_det,
  input  logic             inv,
  input  logic [THR_W-1:0] thr,
  output logic [INC_W-1:0] add
);
  localparam int CMP_W = (INC_W > THR_W) ? INC_W : THR_W;

  logic             seen_q;
  logic             present;
  logic             thr_on;
  logic             meets;
  logic [CMP_W-1:0] inc_x;
  logic [CMP_W-1:0] thr_x;

  assign present = |inc;
  assign inc_x   = CMP_W'(inc);
  assign thr_x   = CMP_W'(thr);
  assign thr_on  = |thr;
  assign meets   = inv ? (inc_x < thr_x) : (inc_x >= thr_x);

  // previous-cycle presence, tracked regardless of enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= present;
  end

  always_comb begin
    if (edge_det)    add = INC_W'(present & ~seen_q);
    else if (thr_on) add = INC_W'(meets);
    else             add = inc;
  end
endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [INC_W-1:0] add,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt} + (CNT_W+1)'(add);
  assign ovf = en & ~ld & sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= ld_val;
    else if (en) cnt <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/ovf_status.sv
module ovf_status #(
  parameter int FLAG_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set,
  input  logic [FLAG_N-1:0] clr,
  output logic [FLAG_N-1:0] flags
);
  // set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter int CNT_W    = 48,
  parameter int INC_W    = 8,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PROG-1:0][INC_W-1:0] prog_inc,
  input  logic [INC_W-1:0]               fix_inc,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic                           irq
);
  localparam int CNT_BASE  = NUM_PROG;
  localparam int FIX_CTL   = 2 * NUM_PROG;
  localparam int FIX_CNT   = FIX_CTL + 1;
  localparam int STAT_ADDR = FIX_CTL + 2;
  localparam int CLR_ADDR  = FIX_CTL + 3;
  localparam int FLAG_N    = NUM_PROG + 1;
  localparam int FIX_BIT   = 31;

  prog_ctl_t [NUM_PROG-1:0]             prog_ctl_q;
  logic      [NUM_PROG-1:0][CNT_W-1:0]  prog_cnt;
  logic      [NUM_PROG-1:0]             prog_ovf;
  logic      [NUM_PROG-1:0]             prog_ie;
  fix_ctl_t                             fix_ctl_q;
  logic      [CNT_W-1:0]                fix_cnt;
  logic                                 fix_ovf;
  logic                                 fix_ld;
  logic      [FLAG_N-1:0]               ovf_flags;
  logic      [FLAG_N-1:0]               clr_vec;
  logic      [31:0]                     stat_word;
  logic                                 clr_wr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PROG; gi++) begin : g_prog
      prog_ctl_t        ctl_q;
      logic [INC_W-1:0] add;
      logic             ld;
      logic [CNT_W-1:0] cnt;
      logic             ovf;

      assign ld = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ctl_q <= '0;
        else if (reg_wr && (reg_addr == ADDR_W'(gi)))
          ctl_q <= prog_ctl_t'(reg_wdata[31:0]);
      end

      evt_qualify #(.INC_W(INC_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (prog_inc[gi]),
        .edge_det (ctl_q.edge_det),
        .inv      (ctl_q.inv),
        .thr      (ctl_q.thr),
        .add      (add)
      );

      evt_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_q.en),
        .ld     (ld),
        .ld_val (reg_wdata[CNT_W-1:0]),
        .add    (add),
        .cnt    (cnt),
        .ovf    (ovf)
      );

      assign prog_ctl_q[gi] = ctl_q;
      assign prog_cnt[gi]   = cnt;
      assign prog_ovf[gi]   = ovf;
      assign prog_ie[gi]    = ctl_q.ovf_ie;
    end
  endgenerate

  // fixed counter
  assign fix_ld = reg_wr && (reg_addr == ADDR_W'(FIX_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fix_ctl_q <= '0;
    else if (reg_wr && (reg_addr == ADDR_W'(FIX_CTL)))
      fix_ctl_q <= fix_ctl_t'(reg_wdata[1:0]);
  end

  evt_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_fix_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (fix_ctl_q.en),
    .ld     (fix_ld),
    .ld_val (reg_wdata[CNT_W-1:0]),
    .add    (fix_inc),
    .cnt    (fix_cnt),
    .ovf    (fix_ovf)
  );

  // overflow status with write-one-to-clear
  assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(CLR_ADDR));
  assign clr_vec = clr_wr ? {reg_wdata[FIX_BIT], reg_wdata[NUM_PROG-1:0]} : '0;

  ovf_status #(.FLAG_N(FLAG_N)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({fix_ovf, prog_ovf}),
    .clr   (clr_vec),
    .flags (ovf_flags)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[NUM_PROG-1:0]   = ovf_flags[NUM_PROG-1:0];
    stat_word[FIX_BIT]        = ovf_flags[NUM_PROG];
  end

  assign irq = |(ovf_flags & {fix_ctl_q.ovf_ie, prog_ie});

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_PROG; i++) begin
      if (reg_addr == ADDR_W'(i))            reg_rdata = DATA_W'(prog_ctl_q[i]);
      if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata = DATA_W'(prog_cnt[i]);
    end
    if (reg_addr == ADDR_W'(FIX_CTL))   reg_rdata = DATA_W'(fix_ctl_q);
    if (reg_addr == ADDR_W'(FIX_CNT))   reg_rdata = DATA_W'(fix_cnt);
    if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = DATA_W'(stat_word);
  end
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter int CNT_W    = 48,
  parameter int INC_W    = 8,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic [DATA_W-1:0]             reg_rdata,
  input logic                          irq,
  input prog_ctl_t [NUM_PROG-1:0]      prog_ctl_q,
  input logic [NUM_PROG-1:0][CNT_W-1:0] prog_cnt,
  input logic [NUM_PROG-1:0]           prog_ovf,
  input fix_ctl_t                      fix_ctl_q,
  input logic [CNT_W-1:0]              fix_cnt,
  input logic                          fix_ovf,
  input logic [NUM_PROG:0]             ovf_flags
);
  localparam int FIX_CTL   = 2 * NUM_PROG;
  localparam int FIX_CNT   = FIX_CTL + 1;
  localparam int STAT_ADDR = FIX_CTL + 2;
  localparam int CLR_ADDR  = FIX_CTL + 3;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PROG; gi++) begin : g_chk
      logic ld;
      assign ld = reg_wr && (reg_addr == ADDR_W'(NUM_PROG + gi));

      AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_ctl_q[gi].en && !ld) |=> $stable(prog_cnt[gi])); // R1

      AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_ctl_q[gi].en && (prog_ctl_q[gi].edge_det || (prog_ctl_q[gi].thr != '0)) && !ld)
        |=> ((prog_cnt[gi] == $past(prog_cnt[gi])) || (prog_cnt[gi] == $past(prog_cnt[gi]) + CNT_W'(1)))); // R3

      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ovf[gi] |=> ovf_flags[gi]); // R10

      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_W'(CLR_ADDR)) && reg_wdata[gi] && !prog_ovf[gi])
        |=> !ovf_flags[gi]); // R9
    end
  endgenerate

  AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_ctl_q.en && !(reg_wr && (reg_addr == ADDR_W'(FIX_CNT)))) |=> $stable(fix_cnt)); // R1

  AST_FIX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fix_ovf |=> ovf_flags[NUM_PROG]); // R7

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CLR_ADDR)) |-> (reg_rdata == '0)); // R9

  AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_ADDR)) |-> (reg_rdata[30:NUM_PROG] == '0)); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flags != '0)); // R11
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
  .NUM_PROG (NUM_PROG),
  .CNT_W    (CNT_W),
  .INC_W    (INC_W),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .prog_ctl_q (prog_ctl_q),
  .prog_cnt   (prog_cnt),
  .prog_ovf   (prog_ovf),
  .fix_ctl_q  (fix_ctl_q),
  .fix_cnt    (fix_cnt),
  .fix_ovf    (fix_ovf),
  .ovf_flags  (ovf_flags)
);

// File: tb/test_evt_ctr_bank.sv
`timescale 1ns/1ps
module test_evt_ctr_bank;
  localparam int NUM_PROG = 4;
  localparam int CNT_W    = 48;
  localparam int INC_W    = 8;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 4;

  localparam int A_CNT0 = 4;
  localparam int A_FCTL = 8;
  localparam int A_FCNT = 9;
  localparam int A_STAT = 10;
  localparam int A_CLR  = 11;
  localparam logic [63:0] CMAX = 64'h0000_FFFF_FFFF_FFFF;

  // {edge, invert, threshold, previous inc, current inc, expected delta}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd0, 8'd0, 8'd5,   8'd5},
    {1'b0, 1'b0, 8'd0, 8'd0, 8'd255, 8'd255},
    {1'b0, 1'b0, 8'd4, 8'd0, 8'd4,   8'd1},
    {1'b0, 1'b0, 8'd4, 8'd0, 8'd200, 8'd1},
    {1'b0, 1'b0, 8'd4, 8'd0, 8'd3,   8'd0},
    {1'b0, 1'b1, 8'd4, 8'd0, 8'd3,   8'd1},
    {1'b0, 1'b1, 8'd4, 8'd0, 8'd4,   8'd0},
    {1'b0, 1'b1, 8'd4, 8'd0, 8'd0,   8'd1},
    {1'b1, 1'b0, 8'd0, 8'd0, 8'd3,   8'd1},
    {1'b1, 1'b0, 8'd0, 8'd2, 8'd3,   8'd0},
    {1'b1, 1'b0, 8'd0, 8'd3, 8'd0,   8'd0},
    {1'b1, 1'b0, 8'd9, 8'd0, 8'd1,   8'd1}
  };

  logic                           clk = 1'b0;
  logic                           rst_n = 1'b0;
  logic [NUM_PROG-1:0][INC_W-1:0] prog_inc = '0;
  logic [INC_W-1:0]               fix_inc = '0;
  logic                           reg_wr = 1'b0;
  logic [ADDR_W-1:0]              reg_addr = '0;
  logic [DATA_W-1:0]              reg_wdata = '0;
  logic [DATA_W-1:0]              reg_rdata;
  logic                           irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  evt_ctr_bank #(
    .NUM_PROG (NUM_PROG), .CNT_W (CNT_W), .INC_W (INC_W),
    .DATA_W (DATA_W), .ADDR_W (ADDR_W)
  ) i_evt_ctr_bank (
    .clk (clk), .rst_n (rst_n), .prog_inc (prog_inc), .fix_inc (fix_inc),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .irq (irq)
  );

  function automatic logic [63:0] pctl(input logic en, ie, edg, inv, input logic [7:0] thr);
    return {32'h0, thr, 4'h0, inv, edg, ie, en, 16'h0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; one clock edge passes
  task automatic wr(input int a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [63:0] v);
    reg_addr = ADDR_W'(a);
    #1;
    v = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R7)
    rd(A_STAT, v);  chk("R7 status after reset", v, 64'h0);
    chk("R11 irq after reset", {63'h0, irq}, 64'h0);
    rd(A_CNT0, v);  chk("R7 counter after reset", v, 64'h0);
    rd(0, v);       chk("R12 control after reset", v, 64'h0);

    // mode table on counter 0
    for (int k = 0; k < NV; k++) begin
      logic [63:0] base;
      string tag;
      base = pctl(1'b0, 1'b0, VEC[k][33], VEC[k][32], VEC[k][31:24]);
      tag  = VEC[k][33] ? "R5" : (VEC[k][32] ? "R4" : ((VEC[k][31:24] != 0) ? "R3" : "R2"));
      wr(0, base);
      wr(A_CNT0, 64'h0);
      prog_inc[0] = VEC[k][23:16];
      reg_wr = 1'b1; reg_addr = '0; reg_wdata = base | 64'h1_0000;
      @(negedge clk);
      prog_inc[0] = VEC[k][15:8];
      reg_wdata = base;
      @(negedge clk);
      reg_wr = 1'b0; prog_inc[0] = '0;
      rd(A_CNT0, v);
      chk($sformatf("%s vector %0d", tag, k), v, {56'h0, VEC[k][7:0]});
    end

    // R12 control readback with select and mask fields
    wr(1, 64'hA5_0_3_5A_C3 & 64'hFFF0_FFFF);
    rd(1, v); chk("R12 control readback", v, 64'hA500_5AC3);

    // R1 hold while disabled
    wr(1, pctl(1'b0, 1'b0, 1'b0, 1'b0, 8'd0));
    wr(A_CNT0 + 1, 64'd100);
    prog_inc[1] = 8'd7;
    repeat (4) @(negedge clk);
    prog_inc[1] = '0;
    rd(A_CNT0 + 1, v); chk("R1 disabled counter holds", v, 64'd100);

    // R6 fixed counter raw count, R1 fixed hold
    wr(A_FCNT, 64'h0);
    wr(A_FCTL, 64'h1);
    fix_inc = 8'd3;
    repeat (3) @(negedge clk);
    fix_inc = '0;
    rd(A_FCNT, v); chk("R6 fixed counter raw sum", v, 64'd9);
    wr(A_FCTL, 64'h0);
    fix_inc = 8'd20;
    repeat (2) @(negedge clk);
    fix_inc = '0;
    rd(A_FCNT, v); chk("R1 fixed counter holds", v, 64'd9);

    // R7 fixed overflow, irq gated by enable (R11)
    wr(A_FCNT, CMAX);
    wr(A_FCTL, 64'h1);
    fix_inc = 8'd2;
    @(negedge clk);
    fix_inc = '0;
    rd(A_FCNT, v); chk("R2 fixed wraps", v, 64'd1);
    rd(A_STAT, v); chk("R7 fixed flag at bit 31", v, 64'h8000_0000);
    chk("R11 irq low with enable off", {63'h0, irq}, 64'h0);
    wr(A_FCTL, 64'h3);
    chk("R11 irq high with enable on", {63'h0, irq}, 64'h1);
    wr(A_FCTL, 64'h0);
    wr(A_CLR, 64'h8000_0000);
    rd(A_STAT, v); chk("R9 fixed flag cleared", v, 64'h0);

    // R2/R7 programmable overflow with wrap
    wr(1, pctl(1'b1, 1'b1, 1'b0, 1'b0, 8'd0));
    wr(A_CNT0 + 1, CMAX - 64'd1);
    prog_inc[1] = 8'd5;
    @(negedge clk);
    prog_inc[1] = '0;
    rd(A_CNT0 + 1, v); chk("R2 counter wraps", v, 64'd3);
    rd(A_STAT, v); chk("R7 flag bit 1", v, 64'h2);
    chk("R11 irq raised", {63'h0, irq}, 64'h1);

    // R8 status writes ignored, spare bits zero
    wr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_STAT, v); chk("R8 status write ignored", v, 64'h2);

    // R9 clear semantics
    wr(A_CLR, 64'h0);
    rd(A_STAT, v); chk("R9 zero write keeps flag", v, 64'h2);
    wr(A_CLR, 64'h1);
    rd(A_STAT, v); chk("R9 other bit keeps flag", v, 64'h2);
    rd(A_CLR, v);  chk("R9 clear reads zero", v, 64'h0);
    wr(A_CLR, 64'h2);
    rd(A_STAT, v); chk("R9 one clears flag", v, 64'h0);
    chk("R11 irq dropped", {63'h0, irq}, 64'h0);

    // R10 set beats clear in the same cycle
    wr(A_CNT0 + 1, CMAX);
    prog_inc[1] = 8'd1;
    @(negedge clk);
    prog_inc[1] = '0;
    wr(A_CNT0 + 1, CMAX);
    prog_inc[1] = 8'd1;
    reg_wr = 1'b1; reg_addr = ADDR_W'(A_CLR); reg_wdata = 64'h2;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; prog_inc[1] = '0;
    rd(A_STAT, v); chk("R10 overflow beats clear", v, 64'h2);
    rd(A_CNT0 + 1, v); chk("R10 counter wrapped to zero", v, 64'h0);
    wr(A_CLR, 64'h2);

    // R12 load overrides counting; unmapped reads zero
    prog_inc[1] = 8'd9;
    reg_wr = 1'b1; reg_addr = ADDR_W'(A_CNT0 + 1); reg_wdata = 64'd50;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; prog_inc[1] = '0;
    rd(A_CNT0 + 1, v); chk("R12 load wins over count", v, 64'd50);
    rd(13, v); chk("R12 unmapped address reads zero", v, 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule